// File: doc/BRIEF.md
# Floating-point exception entry sequencer

This block carries out the processor side of entering a floating-point exception handler. When a request arrives while it is idle, it captures a snapshot of the processor context: the status word, the address of the next instruction to run, the stack pointer and the vector base. It then makes three memory accesses in a fixed order, one at a time:

1. It reads the handler address from the vector table.
2. It pushes the status word onto a stack that grows toward lower addresses.
3. It pushes the return address onto the same stack.

Each push lowers the stack pointer by one 32-bit word before the word is written. After the third access completes, the block issues a single-cycle load strobe. On that cycle it presents the handler address as the new program counter and the lowered stack pointer as the new stack pointer. The jump is not delayed, so no other instruction runs between the last push and the handler.

The memory side has one request outstanding at most. The block holds the request steady until the memory returns an acknowledge. For a read, the data arrives on the acknowledge cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: After a synchronous reset the block is idle: `mem_req_o`, `pc_load_o` and `done_o` are all 0.
- R2: The cycle after `exc_req_i` is seen high in the idle state, the block issues a read (`mem_we_o`=0) at address `vbr_i + VEC_NUM*4`, using the `vbr_i` captured at acceptance. The first access of every sequence is this read.
- R3: After the vector read is acknowledged, the block writes the captured status word at address captured `sp_i - 4`.
- R4: After the status push is acknowledged, the block writes the captured next-PC at address captured `sp_i - 8`, which is the previous push address minus 4.
- R5: The cycle after the PC push is acknowledged, `pc_load_o` is 1 for exactly one cycle. On that cycle `pc_o` equals the word returned by the vector read and `sp_o` equals captured `sp_i - 8`.
- R6: `done_o` is 1 on exactly the cycles on which `pc_load_o` is 1.
- R7: While `mem_ack_i` is 0, an issued request stays asserted, and its address, write enable and write data stay unchanged.
- R8: `exc_req_i` has no effect from acceptance until the load strobe. A request held high past the load strobe starts a new sequence once the block is idle again.
- R9: Changes on `sr_i`, `next_pc_i`, `sp_i` and `vbr_i` after acceptance do not affect the addresses or data of the running sequence.
- R10: No memory request is issued on the load strobe cycle, so the jump has no delay-slot access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req_i | input | 1 | Floating-point exception entry request |
| vbr_i | input | 32 | Vector table base address |
| sr_i | input | 32 | Current status word |
| next_pc_i | input | 32 | Address of the instruction after the last one executed |
| sp_i | input | 32 | Current stack pointer |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge; completes the current access |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ack_i` |
| pc_o | output | 32 | Handler address for the program counter |
| pc_load_o | output | 1 | Program counter load strobe |
| sp_o | output | 32 | Updated stack pointer, valid with `pc_load_o` |
| done_o | output | 1 | Sequence completion pulse |

## Verification
The embedded properties check the following on every cycle:

- A held request keeps its address, data and write enable unchanged while it waits.
- The first access of each sequence is a read.
- The second push lands one word below the first.
- The load strobe lasts one cycle, coincides with the done pulse and never overlaps a memory request.
- A waiting access cannot be disturbed by a new exception request.

Only the bench scenarios can show the end-to-end results. These are the exact stack contents after a sequence, the handler address taken from the read data, immunity to context inputs changing mid-sequence, and the restart when a request is held high. The bench checks these against a behavioural model at several wait-state settings.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int WORD_BYTES = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_VEC_READ = 3'd1,
        ST_PUSH_SR  = 3'd2,
        ST_PUSH_PC  = 3'd3,
        ST_JUMP     = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [ADDR_W-1:0] ret_pc;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] vbr;
        logic [ADDR_W-1:0] handler;
    } exc_ctx_t;

    // Next state of the entry sequence.
    function automatic seq_state_e seq_next(seq_state_e cur, logic req, logic ack);
        seq_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_IDLE:     if (req) nxt = ST_VEC_READ;
            ST_VEC_READ: if (ack) nxt = ST_PUSH_SR;
            ST_PUSH_SR:  if (ack) nxt = ST_PUSH_PC;
            ST_PUSH_PC:  if (ack) nxt = ST_JUMP;
            ST_JUMP:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    // True in states that own a memory access.
    function automatic logic seq_is_access(seq_state_e s);
        return (s == ST_VEC_READ) || (s == ST_PUSH_SR) || (s == ST_PUSH_PC);
    endfunction

    // Pre-decremented push address.
    function automatic logic [ADDR_W-1:0] push_addr(logic [ADDR_W-1:0] sp);
        return sp - ADDR_W'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       exc_req_i,
    input  logic       mem_ack_i,
    output seq_state_e state_o,
    output logic       accept_o,
    output logic       done_o
);

    seq_state_e state_q;
    logic       done_q;

    assign accept_o = (state_q == ST_IDLE) && exc_req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= seq_next(state_q, exc_req_i, mem_ack_i);
            done_q  <= (state_q == ST_PUSH_PC) && mem_ack_i;
        end
    end

    assign state_o = state_q;
    assign done_o  = done_q;

    // R5: the jump state lasts one cycle and returns to idle
    p_jump_single_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_JUMP) |=> (state_q == ST_IDLE));

    // R6: completion pulse coincides with the jump state
    p_done_jump_r6: assert property (@(posedge clk) disable iff (rst)
        done_q == (state_q == ST_JUMP));

    // R8: a waiting access is not disturbed by a new request
    p_req_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_is_access(state_q) && !mem_ack_i) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/exc_entry_ctx.sv
module exc_entry_ctx
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state_i,
    input  logic              accept_i,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic [DATA_W-1:0] sr_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] vbr_i,
    output exc_ctx_t          ctx_o
);

    exc_ctx_t ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (accept_i) begin
            ctx_q.sr     <= sr_i;
            ctx_q.ret_pc <= next_pc_i;
            ctx_q.sp     <= sp_i;
            ctx_q.vbr    <= vbr_i;
        end else if (mem_ack_i) begin
            unique case (state_i)
                ST_VEC_READ: ctx_q.handler <= mem_rdata_i[ADDR_W-1:0];
                ST_PUSH_SR,
                ST_PUSH_PC:  ctx_q.sp      <= push_addr(ctx_q.sp);
                default:     ;
            endcase
        end
    end

    assign ctx_o = ctx_q;

    // R9: the snapshot is frozen once the sequence runs, except for the stack steps
    p_ctx_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (state_i != ST_IDLE) |=> (ctx_q.sr == $past(ctx_q.sr)) &&
                                 (ctx_q.ret_pc == $past(ctx_q.ret_pc)) &&
                                 (ctx_q.vbr == $past(ctx_q.vbr)));

endmodule

// File: rtl/exc_entry_agen.sv
module exc_entry_agen
    import exc_entry_pkg::*;
#(
    parameter int VEC_NUM = 9
) (
    input  seq_state_e state_i,
    input  exc_ctx_t   ctx_i,
    output mem_cmd_t   cmd_o
);

    localparam logic [ADDR_W-1:0] VEC_OFS = ADDR_W'(VEC_NUM * WORD_BYTES);

    always_comb begin
        cmd_o       = '0;
        cmd_o.valid = seq_is_access(state_i);
        unique case (state_i)
            ST_VEC_READ: begin
                cmd_o.addr = ctx_i.vbr + VEC_OFS;
            end
            ST_PUSH_SR: begin
                cmd_o.we    = 1'b1;
                cmd_o.addr  = push_addr(ctx_i.sp);
                cmd_o.wdata = ctx_i.sr;
            end
            ST_PUSH_PC: begin
                cmd_o.we    = 1'b1;
                cmd_o.addr  = push_addr(ctx_i.sp);
                cmd_o.wdata = DATA_W'(ctx_i.ret_pc);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int VEC_NUM = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req_i,
    input  logic [ADDR_W-1:0] vbr_i,
    input  logic [DATA_W-1:0] sr_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              done_o
);

    seq_state_e state;
    logic       accept;
    exc_ctx_t   ctx;
    mem_cmd_t   cmd;

    exc_entry_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .exc_req_i (exc_req_i),
        .mem_ack_i (mem_ack_i),
        .state_o   (state),
        .accept_o  (accept),
        .done_o    (done_o)
    );

    exc_entry_ctx i_ctx (
        .clk         (clk),
        .rst         (rst),
        .state_i     (state),
        .accept_i    (accept),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i),
        .sr_i        (sr_i),
        .next_pc_i   (next_pc_i),
        .sp_i        (sp_i),
        .vbr_i       (vbr_i),
        .ctx_o       (ctx)
    );

    exc_entry_agen #(.VEC_NUM(VEC_NUM)) i_agen (
        .state_i (state),
        .ctx_i   (ctx),
        .cmd_o   (cmd)
    );

    assign mem_req_o   = cmd.valid;
    assign mem_we_o    = cmd.we;
    assign mem_addr_o  = cmd.addr;
    assign mem_wdata_o = cmd.wdata;
    assign pc_load_o   = (state == ST_JUMP);
    assign pc_o        = ctx.handler;
    assign sp_o        = ctx.sp;

    // R1: quiet outputs right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !mem_req_o && !pc_load_o && !done_o);

    // R2: every sequence opens with a read
    p_first_read_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_o) |-> !mem_we_o);

    // R4: the second push lands one word below the first
    p_push_step_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o && mem_ack_i && (state == ST_PUSH_SR)) |=>
            (mem_addr_o == $past(mem_addr_o) - ADDR_W'(WORD_BYTES)));

    // R5: load strobe is a single-cycle pulse
    p_load_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !pc_load_o);

    // R6: done and load strobe coincide
    p_done_load_r6: assert property (@(posedge clk) disable iff (rst)
        done_o == pc_load_o);

    // R7: a waiting request holds its contents
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) &&
                                      $stable(mem_we_o) && $stable(mem_wdata_o));

    // R10: no access on the jump cycle
    p_no_slot_r10: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |-> !mem_req_o);

endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_NUM    = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req_i = 1'b0;
    logic [31:0] vbr_i = '0, sr_i = '0, next_pc_i = '0, sp_i = '0;
    logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
    logic [31:0] pc_o, sp_o;
    logic        pc_load_o, done_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq #(.VEC_NUM(VEC_NUM)) i_exc_entry_seq (
        .clk(clk), .rst(rst), .exc_req_i(exc_req_i), .vbr_i(vbr_i), .sr_i(sr_i),
        .next_pc_i(next_pc_i), .sp_i(sp_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .pc_o(pc_o), .pc_load_o(pc_load_o), .sp_o(sp_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 vector read, 2/3 pushes, 4 jump
    int          m_phase = 0;
    logic [31:0] m_sr, m_pc, m_sp, m_vbr, m_handler;
    logic [31:0] stack_mem [logic [31:0]];

    always @(posedge clk) begin
        if (mem_req_o === 1'b1 && mem_we_o === 1'b1 && mem_ack_i)
            stack_mem[mem_addr_o] = mem_wdata_o;
        if (rst) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (exc_req_i) begin
                       m_sr = sr_i; m_pc = next_pc_i; m_sp = sp_i; m_vbr = vbr_i;
                       m_phase = 1;
                   end
                1: if (mem_ack_i) begin m_handler = mem_rdata_i; m_phase = 2; end
                2: if (mem_ack_i) begin m_sp = m_sp - 4; m_phase = 3; end
                3: if (mem_ack_i) begin m_sp = m_sp - 4; m_phase = 4; end
                default: m_phase = 0;
            endcase
        end
    end

    // Memory responder with configurable wait states
    int          wait_cfg = 0;
    int          wcnt = 0;
    logic [31:0] vec_word = '0;

    always @(negedge clk) begin
        #1;
        if (mem_req_o === 1'b1 && !mem_ack_i) begin
            if (wcnt >= wait_cfg) begin
                mem_ack_i   = 1'b1;
                mem_rdata_i = mem_we_o ? 32'hDEAD_0000 : vec_word;
                wcnt        = 0;
            end else begin
                wcnt++;
            end
        end else begin
            mem_ack_i   = 1'b0;
            mem_rdata_i = 32'h5A5A_5A5A;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        string       t;
        logic [31:0] exp_addr, exp_data;
        bit          exp_req, exp_we;
        exp_req = (m_phase >= 1 && m_phase <= 3);
        exp_we  = (m_phase == 2 || m_phase == 3);
        case (m_phase)
            1: begin t = "R2"; exp_addr = m_vbr + VEC_NUM * 4; exp_data = '0; end
            2: begin t = "R3"; exp_addr = m_sp - 4; exp_data = m_sr; end
            3: begin t = "R4"; exp_addr = m_sp - 4; exp_data = m_pc; end
            4: begin t = "R10"; exp_addr = '0; exp_data = '0; end
            default: begin t = "R1"; exp_addr = '0; exp_data = '0; end
        endcase
        if (exp_req && !mem_ack_i && wait_cfg > 0) t = {t, "/R7"};
        chk(mem_req_o === exp_req, t, 32'(mem_req_o), 32'(exp_req), "mem_req");
        if (exp_req) begin
            chk(mem_we_o === exp_we, t, 32'(mem_we_o), 32'(exp_we), "mem_we");
            chk(mem_addr_o === exp_addr, t, mem_addr_o, exp_addr, "mem_addr");
            if (exp_we) chk(mem_wdata_o === exp_data, t, mem_wdata_o, exp_data, "mem_wdata");
        end
        chk(pc_load_o === (m_phase == 4), "R5", 32'(pc_load_o), 32'(m_phase == 4), "pc_load");
        chk(done_o === (m_phase == 4), "R6", 32'(done_o), 32'(m_phase == 4), "done");
        if (m_phase == 4) begin
            chk(pc_o === m_handler, "R5", pc_o, m_handler, "pc");
            chk(sp_o === m_sp, "R5", sp_o, m_sp, "sp");
        end
    end

    task automatic drive_ctx(input logic [31:0] vbr, sr, pc, sp);
        vbr_i = vbr; sr_i = sr; next_pc_i = pc; sp_i = sp;
    endtask

    task automatic wait_load();
        forever begin
            @(negedge clk);
            if (pc_load_o === 1'b1) break;
        end
    endtask

    task automatic check_stack(input logic [31:0] sp, sr, pc, input string tag);
        chk(stack_mem.exists(sp - 4) && stack_mem[sp - 4] === sr, tag,
            stack_mem.exists(sp - 4) ? stack_mem[sp - 4] : 32'hx, sr, "stacked sr");
        chk(stack_mem.exists(sp - 8) && stack_mem[sp - 8] === pc, tag,
            stack_mem.exists(sp - 8) ? stack_mem[sp - 8] : 32'hx, pc, "stacked pc");
    endtask

    // One sequence started by a single-cycle request pulse
    task automatic run_one(input logic [31:0] vbr, sr, pc, sp, hnd, input int ws);
        @(negedge clk); #2;
        wait_cfg = ws; vec_word = hnd;
        drive_ctx(vbr, sr, pc, sp);
        exc_req_i = 1'b1;
        @(negedge clk); #2;
        exc_req_i = 1'b0;
        wait_load();
        check_stack(sp, sr, pc, "R3/R4");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_req_o === 1'b0 && pc_load_o === 1'b0 && done_o === 1'b0, "R1",
            {29'd0, mem_req_o, pc_load_o, done_o}, 32'd0, "reset outputs");
        #2 rst = 1'b0;

        // Basic sequence, no wait states
        run_one(32'h0000_1000, 32'h0000_00F0, 32'h0000_2222, 32'h0000_8000, 32'h0004_0000, 0);

        // Wait states, inputs changed and request pulsed mid-sequence (R7, R8, R9)
        @(negedge clk); #2;
        wait_cfg = 3; vec_word = 32'hCAFE_0100;
        drive_ctx(32'h2000_0000, 32'h4000_0001, 32'h0010_0ABC, 32'h0001_0000);
        exc_req_i = 1'b1;
        @(negedge clk); #2;
        exc_req_i = 1'b0;
        drive_ctx(32'hFFFF_0000, 32'h1111_1111, 32'h2222_2222, 32'h3333_3330);
        repeat (3) @(negedge clk);
        #2 exc_req_i = 1'b1;
        @(negedge clk); #2 exc_req_i = 1'b0;
        wait_load();
        check_stack(32'h0001_0000, 32'h4000_0001, 32'h0010_0ABC, "R9");
        chk(pc_o === 32'hCAFE_0100, "R5", pc_o, 32'hCAFE_0100, "handler from read");
        begin
            int reqs = 0;
            repeat (6) begin
                @(negedge clk);
                if (mem_req_o === 1'b1) reqs++;
            end
            chk(reqs == 0, "R8", 32'(reqs), 32'd0, "requests after ignored pulse");
        end

        // Request held high across two sequences (R8), stack near address zero
        @(negedge clk); #2;
        wait_cfg = 1; vec_word = 32'h0000_7700;
        drive_ctx(32'h0000_0040, 32'h0000_0003, 32'h0000_0100, 32'h0000_0008);
        exc_req_i = 1'b1;
        wait_load();
        begin
            int starts = 0;
            while (pc_load_o !== 1'b1 || starts == 0) begin
                @(negedge clk);
                if (mem_req_o === 1'b1 && mem_we_o === 1'b0) starts = 1;
                if (starts == 1 && pc_load_o === 1'b1) break;
            end
            chk(starts == 1, "R8", 32'(starts), 32'd1, "held request restarts");
        end
        #2 exc_req_i = 1'b0;
        check_stack(32'h0000_0008, 32'h0000_0003, 32'h0000_0100, "R4");

        // Long wait states
        run_one(32'h8000_0000, 32'hA5A5_A5A5, 32'h1234_5678, 32'hFFFF_FFF0, 32'h0BAD_F00C, 5);
        repeat (4) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=0 run did not complete", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule